// File: doc/BRIEF.md
# Master Clock Auto-Ranging Prescaler

This block turns a master clock, which may run at any of seven permitted rates, into a fixed 256 kHz sequencing enable. The enable is a one-cycle pulse in the master clock domain. The block receives no rate setting. Instead it counts master clock cycles between successive rising edges of the 8 kHz transmit frame sync, maps that count to a divide ratio, and produces 32 enable pulses in every frame once the count is stable.

The permitted rates give 32, 64, 192, 193, 256, 320 or 512 master clocks per frame. Six of them divide evenly, by 1, 2, 6, 8, 10 and 16. The 193-cycle rate does not. For that rate the divider runs at 6 and holds its phase for one master clock just after each frame sync, which absorbs the extra cycle. The divider phase restarts at every frame sync rising edge, so the first pulse of each frame lines up with the sync. Serial data framing has no effect on this block. Frame sync is taken as a level that is synchronous to the master clock.

Top module: `mclk_autoprescale`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `tick` and `locked` are 0 and `ratio_code` is 0.
- R2: A measured period (master clocks between two frame sync rising edges) is classified as follows. 31 to 33 gives code 0 (divide by 1). 63 to 65 gives code 1 (by 2). 191 to 192 gives code 2 (by 6). 193 to 194 gives code 3 (by 6 with one held cycle). 255 to 257 gives code 4 (by 8). 319 to 321 gives code 5 (by 10). 511 to 513 gives code 6 (by 16). `ratio_code` reports the accepted code.
- R3: The first frame sync rising edge after reset only starts measurement. `locked` becomes 1 at the sync edge that closes the second consecutive period in the same class, and `ratio_code` takes that class at the same edge. A single classified period never sets `locked`.
- R4: A period that falls outside every window clears `locked` at the sync edge that closes it and leaves `ratio_code` unchanged.
- R5: A period in a different class from the period before it clears `locked`. The next period in that same new class sets `locked` again, with the new code.
- R6: While locked at a nominal period, every frame contains exactly 32 `tick` pulses.
- R7: Successive ticks are spaced by the divide ratio. With code 3, the gap from the sync-aligned tick to the next tick is 7 cycles, and every later gap is 6.
- R8: In a locked frame, `tick` is high in the cycle right after the clock edge that samples frame sync rising. Only the rising edge matters: the length of the sync pulse has no effect.
- R9: `tick` is high only in the cycle after an edge at which `locked` was 1. No tick occurs while the block is unlocked.
- R10: The period counter saturates at `MAX_PERIOD`. A frame sync that stays absent longer than that yields an out-of-window period, which is handled as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | 8 kHz frame sync, synchronous to `clk` |
| tick | output | 1 | 256 kHz sequencing enable, one `clk` cycle wide |
| locked | output | 1 | Ratio accepted; ticks are being produced |
| ratio_code | output | 3 | Accepted divide-ratio code (see R2) |

## Verification
The bench builds the block with `MAX_PERIOD` set to 600 instead of the default 1023. That keeps every permitted period below the saturation point while letting an 800-cycle gap in frame sync reach saturation in a short run. The bench runs all seven nominal periods, including the non-integer 193-cycle case with its held cycle. It also runs frame pairs that alternate one count above and below nominal, a long sync pulse, an out-of-window period, and a saturated gap. For each case it checks the lock timing, the per-frame tick count and the tick positions against the frame sync.

// File: rtl/amp_pkg.sv
package amp_pkg;

    localparam int TICKS_PER_FRAME = 32;
    localparam int MAX_DIV         = 16;
    localparam int DIV_W           = $clog2(MAX_DIV + 1);
    localparam int PHASE_W         = $clog2(MAX_DIV);
    localparam int PERIOD_W        = 16;
    localparam int NUM_RATES       = 7;

    typedef logic [PERIOD_W-1:0] period_t;
    typedef logic [DIV_W-1:0]    div_t;

    typedef enum logic [2:0] {
        RC_DIV1  = 3'd0,
        RC_DIV2  = 3'd1,
        RC_DIV6  = 3'd2,
        RC_DIV6X = 3'd3,
        RC_DIV8  = 3'd4,
        RC_DIV10 = 3'd5,
        RC_DIV16 = 3'd6,
        RC_NONE  = 3'd7
    } ratio_e;

    // one closed measurement, valid for a single cycle at a sync edge
    typedef struct packed {
        logic    valid;
        period_t count;
    } meas_t;

    typedef struct packed {
        logic   locked;
        ratio_e code;
    } lock_t;

    function automatic div_t div_of(ratio_e c);
        case (c)
            RC_DIV1:  return div_t'(1);
            RC_DIV2:  return div_t'(2);
            RC_DIV6:  return div_t'(6);
            RC_DIV6X: return div_t'(6);
            RC_DIV8:  return div_t'(8);
            RC_DIV10: return div_t'(10);
            RC_DIV16: return div_t'(16);
            default:  return div_t'(1);
        endcase
    endfunction

    function automatic logic has_slip(ratio_e c);
        return c == RC_DIV6X;
    endfunction

    function automatic period_t nominal(ratio_e c);
        return period_t'(TICKS_PER_FRAME * int'(div_of(c)) + (has_slip(c) ? 1 : 0));
    endfunction

    // windows are +/-1, except that 192 and 193 split their shared edge
    function automatic period_t window_lo(ratio_e c);
        return (c == RC_DIV6X) ? nominal(c) : nominal(c) - period_t'(1);
    endfunction

    function automatic period_t window_hi(ratio_e c);
        return (c == RC_DIV6) ? nominal(c) : nominal(c) + period_t'(1);
    endfunction

endpackage

// File: rtl/amp_period_meter.sv
module amp_period_meter
    import amp_pkg::*;
#(
    parameter int MAX_PERIOD = 1023
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  fsync,
    output logic  rise,
    output meas_t meas
);

    localparam period_t SAT = period_t'(MAX_PERIOD);

    logic    fs_q;
    logic    seen;
    period_t cnt;

    assign rise       = fsync & ~fs_q;
    assign meas.valid = rise & seen;
    assign meas.count = cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_q <= 1'b0;
            seen <= 1'b0;
            cnt  <= '0;
        end else begin
            fs_q <= fsync;
            if (rise) begin
                cnt  <= period_t'(1);
                seen <= 1'b1;
            end else if (cnt < SAT) begin
                cnt <= cnt + period_t'(1);
            end
        end
    end

    AST_PERIOD_SATURATES: assert property (@(posedge clk) disable iff (rst)
        cnt <= SAT); // R10

    AST_COUNT_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        rise |=> (cnt == period_t'(1))); // R10

endmodule

// File: rtl/amp_ratio_lock.sv
module amp_ratio_lock
    import amp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  meas_t meas,
    output lock_t st
);

    logic [NUM_RATES-1:0] hit;
    ratio_e               cls;
    ratio_e               prev_cls;

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_win
        assign hit[g] = (meas.count >= window_lo(ratio_e'(3'(g)))) &&
                        (meas.count <= window_hi(ratio_e'(3'(g))));
    end

    always_comb begin
        cls = RC_NONE;
        for (int k = NUM_RATES - 1; k >= 0; k--) begin
            if (hit[k]) cls = ratio_e'(3'(k));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.locked <= 1'b0;
            st.code   <= RC_DIV1;
            prev_cls  <= RC_NONE;
        end else if (meas.valid) begin
            prev_cls <= cls;
            if (cls == RC_NONE) begin
                st.locked <= 1'b0;
            end else if (cls == prev_cls) begin
                st.locked <= 1'b1;
                st.code   <= cls;
            end else begin
                st.locked <= 1'b0;
            end
        end
    end

    AST_WINDOWS_DISJOINT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit)); // R2

    AST_LOCK_FROM_MEASURE: assert property (@(posedge clk) disable iff (rst)
        $rose(st.locked) |-> $past(meas.valid)); // R3

    AST_BAD_PERIOD_UNLOCKS: assert property (@(posedge clk) disable iff (rst)
        (meas.valid && cls == RC_NONE) |=> (!st.locked && $stable(st.code))); // R4

    AST_CODE_HOLDS_BETWEEN_SYNCS: assert property (@(posedge clk) disable iff (rst)
        !meas.valid |=> $stable(st.code)); // R4

endmodule

// File: rtl/amp_tick_divider.sv
module amp_tick_divider
    import amp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rise,
    input  lock_t st,
    output logic  tick
);

    logic [PHASE_W-1:0] phase;
    logic               slip_pend;
    div_t               div;
    logic               wrap;

    assign div  = div_of(st.code);
    assign wrap = (div_t'(phase) == div - div_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= '0;
            slip_pend <= 1'b0;
            tick      <= 1'b0;
        end else begin
            tick <= st.locked & (rise | (~slip_pend & wrap));
            if (rise) begin
                phase     <= '0;
                slip_pend <= has_slip(st.code);
            end else if (slip_pend) begin
                slip_pend <= 1'b0;
            end else if (wrap) begin
                phase <= '0;
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

    AST_SLIP_ONLY_EXTENDED: assert property (@(posedge clk) disable iff (rst)
        slip_pend |-> ($past(st.code) == RC_DIV6X)); // R7

    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (rst)
        div_t'(phase) < div); // R7

endmodule

// File: rtl/mclk_autoprescale.sv
module mclk_autoprescale
    import amp_pkg::*;
#(
    parameter int MAX_PERIOD = 1023
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fsync,
    output logic       tick,
    output logic       locked,
    output logic [2:0] ratio_code
);

    logic  rise;
    meas_t meas;
    lock_t lk;

    amp_period_meter #(.MAX_PERIOD(MAX_PERIOD)) u_meter (
        .clk   (clk),
        .rst   (rst),
        .fsync (fsync),
        .rise  (rise),
        .meas  (meas)
    );

    amp_ratio_lock u_lock (
        .clk  (clk),
        .rst  (rst),
        .meas (meas),
        .st   (lk)
    );

    amp_tick_divider u_div (
        .clk  (clk),
        .rst  (rst),
        .rise (rise),
        .st   (lk),
        .tick (tick)
    );

    assign locked     = lk.locked;
    assign ratio_code = lk.code;

    AST_TICK_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
        tick |-> $past(lk.locked)); // R9

    AST_SYNC_ALIGNED_TICK: assert property (@(posedge clk) disable iff (rst)
        (lk.locked && rise) |=> tick); // R8

endmodule

// File: tb/mclk_autoprescale_tb_top.sv
`timescale 1ns/1ps
module mclk_autoprescale_tb_top;

    localparam int BENCH_MAX = 600;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fsync = 1'b0;
    logic       tick;
    logic       locked;
    logic [2:0] ratio_code;

    int n_tests = 0;
    int n_fail  = 0;

    int f_ticks;
    int f_late;
    int f_pos [3];

    always #5 clk = ~clk;

    mclk_autoprescale #(.MAX_PERIOD(BENCH_MAX)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .fsync      (fsync),
        .tick       (tick),
        .locked     (locked),
        .ratio_code (ratio_code)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one frame of n cycles, sync high for w of them; tick sampled 1 ns after each edge
    task automatic do_frame(input int n, input int w);
        f_ticks = 0;
        f_late  = 0;
        for (int k = 0; k < 3; k++) f_pos[k] = -1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            fsync = (i < w);
            @(posedge clk);
            #1;
            if (tick) begin
                if (f_ticks < 3) f_pos[f_ticks] = i;
                f_ticks++;
                if (i > 0) f_late++;
            end
        end
    endtask

    task automatic test_reset();
        rst   = 1'b1;
        fsync = 1'b0;
        repeat (4) @(negedge clk);
        check(tick == 1'b0, "R1 tick in reset", int'(tick), 0);
        check(locked == 1'b0, "R1 locked in reset", int'(locked), 0);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check(tick == 1'b0, "R1 tick after reset", int'(tick), 0);
        check(locked == 1'b0, "R1 locked after reset", int'(locked), 0);
        check(ratio_code == 3'd0, "R1 ratio_code after reset", int'(ratio_code), 0);
    endtask

    task automatic test_rate(input int na, input int nb, input int w,
                             input int exp_code, input int d, input bit exact);
        do_frame(na, w);
        do_frame(nb, w);
        check(locked == 1'b0, "R3/R5 no lock on first period of class", int'(locked), 0);
        check(f_late == 0, "R9 no ticks while unlocked", f_late, 0);
        do_frame(na, w);
        check(locked == 1'b1, "R3 lock after two matching periods", int'(locked), 1);
        check(int'(ratio_code) == exp_code, "R2 ratio code", int'(ratio_code), exp_code);
        do_frame(nb, w);
        if (exact) begin
            check(f_ticks == 32, "R6 ticks per frame", f_ticks, 32);
            check(f_pos[0] == 0, "R8 first tick at sync", f_pos[0], 0);
            check(f_pos[1] - f_pos[0] == ((exp_code == 3) ? 7 : d),
                  "R7 first gap", f_pos[1] - f_pos[0], (exp_code == 3) ? 7 : d);
            check(f_pos[2] - f_pos[1] == d, "R7 steady gap", f_pos[2] - f_pos[1], d);
        end
    endtask

    task automatic test_bad_period();
        do_frame(300, 1);
        do_frame(256, 1);
        check(locked == 1'b0, "R4 out-of-window clears lock", int'(locked), 0);
        check(ratio_code == 3'd4, "R4 ratio code kept", int'(ratio_code), 4);
        check(f_late == 0, "R9 no ticks after unlock", f_late, 0);
    endtask

    task automatic test_saturation();
        do_frame(256, 1);
        do_frame(800, 1);
        check(locked == 1'b1, "R3 relock before gap", int'(locked), 1);
        do_frame(256, 1);
        check(locked == 1'b0, "R10 saturated gap clears lock", int'(locked), 0);
        check(ratio_code == 3'd4, "R10 ratio code kept", int'(ratio_code), 4);
        check(f_late == 0, "R9 no ticks after gap", f_late, 0);
    endtask

    initial begin
        #(200000 * 10);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        test_reset();
        test_rate(32,  32,  1,  0, 1,  1'b1);
        test_rate(64,  64,  1,  1, 2,  1'b1);
        test_rate(192, 192, 1,  2, 6,  1'b1);
        test_rate(193, 193, 1,  3, 6,  1'b1);
        test_rate(256, 256, 1,  4, 8,  1'b1);
        test_rate(320, 320, 40, 5, 10, 1'b1); // R8 long sync pulse
        test_rate(512, 512, 1,  6, 16, 1'b1);
        test_rate(191, 192, 1,  2, 6,  1'b0); // R2 lower window
        test_rate(193, 194, 1,  3, 6,  1'b0); // R2 split window
        test_rate(255, 257, 1,  4, 8,  1'b0); // R2 +/-1
        test_bad_period();
        test_saturation();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule